// File: doc/BRIEF.md
# Mode-Aware Memory Access Guard

This block stands between a small processor and its three memories (ROM, EEPROM and RAM) and rules on every read, write and instruction fetch before the memory sees it. The ruling depends on the current execution mode, the type of operation, the configured size of the application EEPROM window, and whether the boot phase has ended. The processor drives one unified address. The guard decodes the target memory and the byte offset from it, and enables that memory only when the access is allowed.

There are four execution modes. Test mode reaches everything. Boot and configuration modes are limited to the test ROM, the manufacturer EEPROM area, the configured application EEPROM window and, while it exists, the small boot RAM region. System mode reaches the application ROM, the application EEPROM window and the application RAM. During boot, RAM holds a 128-byte boot region at its low end, and the application region covers the remaining 6016 bytes. A one-shot end-of-boot event removes the boot region, and from then on the application region spans all 6144 bytes until the next reset.

The ruling is combinational, so a granted access costs no extra cycle. A denied access raises a registered violation pulse one cycle later for the exception logic. Read data comes back from the synchronous memories one cycle after the request and is forced to zero if the read was not granted.

Top module: `mem_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it with no request, `violation`, `cpu_rdata`, `grant` and `mem_en` are all zero, and the boot RAM region is present.
- R2: Address map, decoded from the top two bits of `req_addr`. Bank 0 is ROM: application ROM at offsets 0..200703, test ROM at 200704..221183. Bank 1 is EEPROM: manufacturer area at offsets 0..127, application EEPROM at 128..12415. Bank 2 is RAM at offsets 0..6143. Bank 3, and every offset beyond a memory's end, is unmapped and always denied. In test mode (`cur_mode`=1) every mapped address is granted for every valid operation.
- R3: In boot mode (`cur_mode`=0) and configuration mode (`cur_mode`=2), the following are granted and nothing else is: test ROM for read or execute; manufacturer EEPROM and the configured application EEPROM window for read or write; the boot RAM region for read or write.
- R4: In system mode (`cur_mode`=3), application ROM is granted for read and execute. Writes to ROM are denied, and any access to the test ROM is denied.
- R5: The manufacturer EEPROM area (offsets 0..127) is never granted in system mode.
- R6: The application EEPROM window starts at offset 128 and is 4096 bytes for `eep_size_sel`=0 or 3, 8192 for 1, and 12288 for 2. Outside test mode, an application EEPROM offset at or beyond the window is denied. In system mode the window is granted for read, write and execute.
- R7: Before the end of boot, RAM offsets 0..127 form the boot region, which is open only to boot and configuration modes. System mode gets offsets 128..6143. After the end of boot, system mode gets 0..6143 and the boot region is gone.
- R8: A one-cycle `boot_done` pulse ends boot permanently. Only reset brings back the boot RAM region.
- R9: `req_op` encodes 0 read, 1 write, 2 execute, and 3 invalid. Code 3 is denied in every mode. Execute from RAM is denied in system mode.
- R10: `grant`, `mem_en` and `mem_off` follow the request in the same cycle. `mem_en` is one-hot (bit 0 ROM, bit 1 EEPROM, bit 2 RAM) on a grant and all zero otherwise. `mem_off` is `req_addr[17:0]`.
- R11: `violation` is high in the cycle after each denied valid request and low after any other cycle.
- R12: `cpu_rdata`, one cycle after a granted read, equals the read data of the memory that was enabled. After any other request, or no request, it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 20 | Unified processor address |
| req_op | input | 2 | Operation: 0 read, 1 write, 2 execute, 3 invalid |
| cur_mode | input | 2 | Execution mode: 0 boot, 1 test, 2 configuration, 3 system |
| eep_size_sel | input | 2 | Application EEPROM window size selector |
| boot_done | input | 1 | End-of-boot event, sticky once seen |
| grant | output | 1 | Access allowed, same cycle |
| mem_en | output | 3 | Per-memory enable: bit 0 ROM, 1 EEPROM, 2 RAM |
| mem_off | output | 18 | Byte offset within the selected memory |
| rom_rdata | input | 8 | ROM read data, one cycle after enable |
| eep_rdata | input | 8 | EEPROM read data, one cycle after enable |
| ram_rdata | input | 8 | RAM read data, one cycle after enable |
| cpu_rdata | output | 8 | Read data returned to the processor |
| violation | output | 1 | One-cycle denied-access pulse |

## Verification
`grant`, `mem_en` and `mem_off` are combinational, so the bench samples them 1 ns after it drives a request at the falling edge, before any clock edge intervenes. `violation` and `cpu_rdata` each pass through one register, so they are sampled 1 ns after the next rising edge, while the request that caused them is still the one on the inputs. The end-of-boot flag also takes one register stage. The bench updates its behavioural model only after the rising edge that captures the pulse, and issues later requests only after that edge.

// File: rtl/mg_pkg.sv
package mg_pkg;

  typedef enum logic [1:0] {
    MD_BOOT = 2'd0,
    MD_TEST = 2'd1,
    MD_CFG  = 2'd2,
    MD_SYS  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_WR  = 2'd1,
    OP_EX  = 2'd2,
    OP_BAD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_APP_ROM,
    RG_TEST_ROM,
    RG_MFG_EEP,
    RG_EEP_IN,
    RG_EEP_OUT,
    RG_BOOT_RAM,
    RG_APP_RAM
  } region_e;

  localparam int MEM_N   = 3;
  localparam int MEM_ROM = 0;
  localparam int MEM_EEP = 1;
  localparam int MEM_RAM = 2;

endpackage

// File: rtl/mg_decode.sv
module mg_decode
  import mg_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int OFF_W          = 18,
  parameter int APP_ROM_BYTES  = 200704,
  parameter int TEST_ROM_BYTES = 20480,
  parameter int MFG_EEP_BYTES  = 128,
  parameter int EEP_UNIT_BYTES = 4096,
  parameter int EEP_UNITS_MAX  = 3,
  parameter int BOOT_RAM_BYTES = 128,
  parameter int RAM_BYTES      = 6144
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        eep_sel,
  input  logic              boot_over,
  output region_e           region,
  output logic [MEM_N-1:0]  hit,
  output logic [OFF_W-1:0]  off
);

  localparam int BANK_W = ADDR_W - OFF_W;
  localparam logic [OFF_W-1:0] APP_ROM_END = OFF_W'(APP_ROM_BYTES);
  localparam logic [OFF_W-1:0] ROM_END     = OFF_W'(APP_ROM_BYTES + TEST_ROM_BYTES);
  localparam logic [OFF_W-1:0] MFG_END     = OFF_W'(MFG_EEP_BYTES);
  localparam logic [OFF_W-1:0] EEP_END     = OFF_W'(MFG_EEP_BYTES + EEP_UNIT_BYTES * EEP_UNITS_MAX);
  localparam logic [OFF_W-1:0] BOOT_END    = OFF_W'(BOOT_RAM_BYTES);
  localparam logic [OFF_W-1:0] RAM_END     = OFF_W'(RAM_BYTES);

  // Size of the application EEPROM window for a selector value.
  function automatic logic [OFF_W-1:0] eep_win(input logic [1:0] sel);
    case (sel)
      2'd1:    eep_win = OFF_W'(2 * EEP_UNIT_BYTES);
      2'd2:    eep_win = OFF_W'(3 * EEP_UNIT_BYTES);
      default: eep_win = OFF_W'(EEP_UNIT_BYTES);
    endcase
  endfunction

  logic [BANK_W-1:0] bank;
  logic [OFF_W-1:0]  eep_rel;

  assign bank    = addr[ADDR_W-1:OFF_W];
  assign off     = addr[OFF_W-1:0];
  assign eep_rel = off - MFG_END;

  always_comb begin
    region = RG_NONE;
    hit    = '0;
    if (bank == BANK_W'(MEM_ROM)) begin
      if (off < APP_ROM_END) begin
        region = RG_APP_ROM;
        hit[MEM_ROM] = 1'b1;
      end else if (off < ROM_END) begin
        region = RG_TEST_ROM;
        hit[MEM_ROM] = 1'b1;
      end
    end else if (bank == BANK_W'(MEM_EEP)) begin
      if (off < MFG_END) begin
        region = RG_MFG_EEP;
        hit[MEM_EEP] = 1'b1;
      end else if (off < EEP_END) begin
        region = (eep_rel < eep_win(eep_sel)) ? RG_EEP_IN : RG_EEP_OUT;
        hit[MEM_EEP] = 1'b1;
      end
    end else if (bank == BANK_W'(MEM_RAM)) begin
      if (off < RAM_END) begin
        region = (!boot_over && off < BOOT_END) ? RG_BOOT_RAM : RG_APP_RAM;
        hit[MEM_RAM] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mg_policy.sv
module mg_policy
  import mg_pkg::*;
(
  input  mode_e   mode,
  input  op_e     op,
  input  region_e region,
  output logic    allow
);

  function automatic logic rule(input mode_e m, input op_e o, input region_e r);
    logic rd_ex, rd_wr;
    rd_ex = (o == OP_RD) || (o == OP_EX);
    rd_wr = (o == OP_RD) || (o == OP_WR);
    rule  = 1'b0;
    if (o != OP_BAD && r != RG_NONE) begin
      case (m)
        MD_TEST: rule = 1'b1;
        MD_SYS: begin
          case (r)
            RG_APP_ROM: rule = rd_ex;
            RG_EEP_IN:  rule = 1'b1;
            RG_APP_RAM: rule = rd_wr;
            default:    rule = 1'b0;
          endcase
        end
        default: begin
          case (r)
            RG_TEST_ROM:                      rule = rd_ex;
            RG_MFG_EEP, RG_EEP_IN, RG_BOOT_RAM: rule = rd_wr;
            default:                          rule = 1'b0;
          endcase
        end
      endcase
    end
  endfunction

  assign allow = rule(mode, op, region);

endmodule

// File: rtl/mg_boot_state.sv
module mg_boot_state (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_done,
  output logic boot_over
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         boot_over <= 1'b0;
    else if (boot_done) boot_over <= 1'b1;
  end

  assert_boot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_over |=> boot_over);

  assert_boot_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_over);

endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int OFF_W          = 18,
  parameter int DATA_W         = 8,
  parameter int APP_ROM_BYTES  = 200704,
  parameter int TEST_ROM_BYTES = 20480,
  parameter int MFG_EEP_BYTES  = 128,
  parameter int EEP_UNIT_BYTES = 4096,
  parameter int EEP_UNITS_MAX  = 3,
  parameter int BOOT_RAM_BYTES = 128,
  parameter int RAM_BYTES      = 6144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic [1:0]        cur_mode,
  input  logic [1:0]        eep_size_sel,
  input  logic              boot_done,
  output logic              grant,
  output logic [MEM_N-1:0]  mem_en,
  output logic [OFF_W-1:0]  mem_off,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] eep_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              violation
);

  mode_e   mode;
  op_e     op;
  region_e region;
  logic [MEM_N-1:0] hit;
  logic             allow;
  logic             boot_over;
  logic             deny_evt;
  logic             rd_grant;
  logic [MEM_N-1:0] rd_sel_q;
  logic [DATA_W-1:0] mem_data [MEM_N];
  logic [DATA_W-1:0] gated    [MEM_N];

  assign mode = mode_e'(cur_mode);
  assign op   = op_e'(req_op);

  mg_boot_state u_boot (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_done (boot_done),
    .boot_over (boot_over)
  );

  mg_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .APP_ROM_BYTES(APP_ROM_BYTES), .TEST_ROM_BYTES(TEST_ROM_BYTES),
    .MFG_EEP_BYTES(MFG_EEP_BYTES), .EEP_UNIT_BYTES(EEP_UNIT_BYTES),
    .EEP_UNITS_MAX(EEP_UNITS_MAX), .BOOT_RAM_BYTES(BOOT_RAM_BYTES),
    .RAM_BYTES(RAM_BYTES)
  ) u_dec (
    .addr      (req_addr),
    .eep_sel   (eep_size_sel),
    .boot_over (boot_over),
    .region    (region),
    .hit       (hit),
    .off       (mem_off)
  );

  mg_policy u_pol (
    .mode   (mode),
    .op     (op),
    .region (region),
    .allow  (allow)
  );

  assign grant    = req_valid & allow;
  assign deny_evt = req_valid & ~allow;
  assign rd_grant = grant & (op == OP_RD);

  assign mem_data[MEM_ROM] = rom_rdata;
  assign mem_data[MEM_EEP] = eep_rdata;
  assign mem_data[MEM_RAM] = ram_rdata;

  for (genvar i = 0; i < MEM_N; i++) begin : g_mem
    assign mem_en[i] = grant & hit[i];
    assign gated[i]  = rd_sel_q[i] ? mem_data[i] : '0;
  end

  always_comb begin
    cpu_rdata = '0;
    for (int i = 0; i < MEM_N; i++) cpu_rdata = cpu_rdata | gated[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      violation <= 1'b0;
      rd_sel_q  <= '0;
    end else begin
      violation <= deny_evt;
      rd_sel_q  <= rd_grant ? hit : '0;
    end
  end

  assert_en_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_en));

  assert_no_en_on_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |-> (mem_en == '0));

  assert_viol_after_deny_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grant) |=> violation);

  assert_viol_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !grant) |=> !violation);

  assert_rdata_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && grant && req_op == 2'd0) |=> (cpu_rdata == '0));

  assert_mfg_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == MD_SYS && region == RG_MFG_EEP) |-> !grant);

  assert_no_ram_exec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode == MD_SYS && hit[MEM_RAM] && req_op == 2'd2) |-> !grant);

endmodule

// File: tb/mem_guard_test.sv
`timescale 1ns/1ps
module mem_guard_test;

  localparam int ROM_B = 0;
  localparam int EEP_B = 262144;
  localparam int RAM_B = 524288;
  localparam logic [7:0] ROM_D = 8'hA5;
  localparam logic [7:0] EEP_D = 8'h3C;
  localparam logic [7:0] RAM_D = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [1:0]  cur_mode = '0;
  logic [1:0]  eep_size_sel = '0;
  logic        boot_done = 1'b0;
  logic        grant;
  logic [2:0]  mem_en;
  logic [17:0] mem_off;
  logic [7:0]  cpu_rdata;
  logic        violation;

  int checks = 0;
  int errors = 0;
  bit boot_ended = 1'b0;

  always #5 clk = ~clk;

  mem_guard uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .cur_mode(cur_mode), .eep_size_sel(eep_size_sel),
    .boot_done(boot_done), .grant(grant), .mem_en(mem_en), .mem_off(mem_off),
    .rom_rdata(ROM_D), .eep_rdata(EEP_D), .ram_rdata(RAM_D),
    .cpu_rdata(cpu_rdata), .violation(violation)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model over absolute byte addresses.
  function automatic bit model(input int md, input int op, input int a, input int sel,
                               input bit bov, output int mem);
    int off, win;
    mem = -1;
    off = 0;
    if (a < 221184) begin mem = 0; off = a; end
    else if (a >= EEP_B && a < EEP_B + 12416) begin mem = 1; off = a - EEP_B; end
    else if (a >= RAM_B && a < RAM_B + 6144) begin mem = 2; off = a - RAM_B; end
    if (mem < 0 || op == 3) return 0;
    if (md == 1) return 1;
    win = (sel == 1) ? 8192 : (sel == 2) ? 12288 : 4096;
    if (md == 3) begin
      if (mem == 0) return off < 200704 && op != 1;
      if (mem == 1) return off >= 128 && off - 128 < win;
      return (bov || off >= 128) && op != 2;
    end
    if (mem == 0) return off >= 200704 && op != 1;
    if (mem == 1) return (off < 128 || off - 128 < win) && op != 2;
    return !bov && off < 128 && op != 2;
  endfunction

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic req(input int md, input int op, input int a, input int sel, input string tag);
    bit exp_g;
    int mem;
    int exp_d;
    cur_mode = md[1:0]; req_op = op[1:0]; req_addr = a[19:0];
    eep_size_sel = sel[1:0]; req_valid = 1'b1;
    exp_g = model(md, op, a, sel, boot_ended, mem);
    #1;
    chk(grant == exp_g, {tag, " grant"}, grant, exp_g);
    chk(mem_en == (exp_g ? 3'(1 << mem) : 3'd0), {tag, " R10 mem_en"}, mem_en,
        exp_g ? (1 << mem) : 0);
    chk(mem_off == 18'(a % 262144), {tag, " R10 mem_off"}, mem_off, a % 262144);
    exp_d = (exp_g && op == 0) ? ((mem == 0) ? ROM_D : (mem == 1) ? EEP_D : RAM_D) : 0;
    @(posedge clk); #1;
    chk(violation == !exp_g, {tag, " R11 violation"}, violation, !exp_g);
    chk(cpu_rdata == 8'(exp_d), {tag, " R12 rdata"}, cpu_rdata, exp_d);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    req_valid = 1'b0;
    @(posedge clk); #1;
    chk(violation == 1'b0, {tag, " R11 idle violation"}, violation, 0);
    chk(cpu_rdata == 8'd0, {tag, " R12 idle rdata"}, cpu_rdata, 0);
    @(negedge clk);
  endtask

  task automatic end_boot();
    boot_done = 1'b1;
    @(posedge clk); #1;
    boot_ended = 1'b1;
    @(negedge clk);
    boot_done = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    chk(violation == 1'b0, "R1 violation in reset", violation, 0);
    chk(cpu_rdata == 8'd0, "R1 rdata in reset", cpu_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(grant == 1'b0, "R1 grant idle", grant, 0);
    chk(mem_en == 3'd0, "R1 mem_en idle", mem_en, 0);
    @(negedge clk);
    req(0, 1, RAM_B + 5, 0, "R1 boot region present");

    // R2 test mode
    req(1, 1, ROM_B + 100, 0, "R2 test rom write");
    req(1, 2, EEP_B + 3, 0, "R2 test mfg exec");
    req(1, 0, EEP_B + 128 + 5000, 0, "R2 test eep beyond window");
    req(1, 0, RAM_B + 6143, 0, "R2 test ram top");
    req(1, 0, ROM_B + 221184, 0, "R2 unmapped rom gap");
    req(1, 0, 786432 + 4, 0, "R2 bank 3");
    req(1, 0, RAM_B + 6144, 0, "R2 past ram end");
    req(1, 0, EEP_B + 12416, 2, "R2 past eep end");

    // R3 boot and configuration
    req(0, 0, ROM_B + 200704, 0, "R3 boot test rom read");
    req(0, 2, ROM_B + 221183, 0, "R3 boot test rom exec");
    req(0, 1, ROM_B + 200704, 0, "R3 boot test rom write");
    req(0, 0, ROM_B + 10, 0, "R3 boot app rom");
    req(0, 1, EEP_B + 0, 0, "R3 boot mfg write");
    req(0, 0, EEP_B + 200, 0, "R3 boot eep window");
    req(0, 2, EEP_B + 200, 0, "R3 boot eep exec");
    req(0, 0, EEP_B + 128 + 4096, 0, "R3 boot eep outside");
    req(0, 0, RAM_B + 200, 0, "R3 boot app ram");
    req(2, 0, ROM_B + 205000, 0, "R3 cfg test rom");
    req(2, 1, EEP_B + 127, 0, "R3 cfg mfg write");
    req(2, 0, ROM_B + 0, 0, "R3 cfg app rom");

    // R4 system ROM
    req(3, 2, ROM_B + 200703, 0, "R4 sys app rom exec");
    req(3, 0, ROM_B + 0, 0, "R4 sys app rom read");
    req(3, 1, ROM_B + 40, 0, "R4 sys rom write");
    req(3, 0, ROM_B + 200704, 0, "R4 sys test rom");

    // R5 manufacturer area
    req(3, 0, EEP_B + 0, 2, "R5 sys mfg low");
    req(3, 1, EEP_B + 127, 2, "R5 sys mfg high");
    req(3, 0, EEP_B + 128, 2, "R5 sys first app byte");

    // R6 window sizes
    req(3, 1, EEP_B + 128 + 4095, 0, "R6 4K last");
    req(3, 0, EEP_B + 128 + 4096, 0, "R6 4K beyond");
    req(3, 2, EEP_B + 128 + 8191, 1, "R6 8K last exec");
    req(3, 0, EEP_B + 128 + 8192, 1, "R6 8K beyond");
    req(3, 0, EEP_B + 128 + 12287, 2, "R6 12K last");
    req(3, 0, EEP_B + 128 + 4096, 3, "R6 sel3 as 4K");
    req(2, 1, EEP_B + 128 + 8191, 1, "R6 cfg 8K last");

    // R7 RAM partition before end of boot
    req(3, 0, RAM_B + 127, 0, "R7 sys boot region");
    req(3, 1, RAM_B + 128, 0, "R7 sys app ram low");
    req(3, 0, RAM_B + 6143, 0, "R7 sys app ram top");
    req(3, 0, RAM_B + 6144, 0, "R7 sys ram end");

    // R9 operation codes
    req(3, 2, RAM_B + 300, 0, "R9 sys ram exec");
    req(1, 3, ROM_B + 5, 0, "R9 invalid op test");
    req(3, 3, EEP_B + 200, 0, "R9 invalid op sys");
    idle("R11 after deny");

    // R7/R8 end of boot
    end_boot();
    repeat (4) idle("R8 idle");
    req(3, 1, RAM_B + 0, 0, "R7 sys ram 0 after boot");
    req(3, 0, RAM_B + 127, 0, "R8 sys ram 127 sticky");
    req(0, 0, RAM_B + 0, 0, "R7 boot region gone");
    req(2, 1, RAM_B + 64, 0, "R7 cfg boot region gone");

    // R8 reset restores the boot region
    rst_n = 1'b0;
    boot_ended = 1'b0;
    req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    req(0, 0, RAM_B + 0, 0, "R8 boot region after reset");
    req(3, 0, RAM_B + 0, 0, "R8 sys denied after reset");
    idle("R11 final");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule